// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers fifteen interrupt request lines and decides which one the processor should service next. Two of the lines come from active-low external pins. Four come from capture pins that act as edge-triggered interrupts. The other nine are level requests held by on-chip peripherals: two timers, three compare channels, a capture-timer overflow, an ADC, a CAN controller and a UART. Each source has an enable bit and a priority bit. One global enable gates all of them.

The processor sees a request line and a 4-bit vector index. It answers with a one-cycle acknowledge and later a one-cycle return pulse. The controller keeps two in-service bits, one per priority level. These implement two-level nesting: a high-priority request may interrupt a low-priority routine, and nothing interrupts a high-priority routine. A DMA-busy input blocks all grants. An idle-mode input stops capture-edge detection, and a separate wake output reports requests that are allowed to end idle mode.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_req and wake_req are 0, irq_vec is 0, and both in-service levels are clear.
- R2: A source is granted only while glob_en is 1 and its bit in src_en is 1. Clearing either one removes the request from irq_req.
- R3: When several enabled sources are pending at the same priority level, the source with the smaller vector index is granted.
- R4: A pending high-priority source (src_hi bit = 1) is granted while a low-priority routine is in service.
- R5: No request is granted while a high-priority routine is in service. No low-priority request is granted while any routine is in service.
- R6: A ret pulse clears the high in-service level if it is set, and otherwise clears the low level. A lower level stays in service when a higher one is cleared.
- R7: While dma_busy is 1, irq_req is 0.
- R8: An external pin in level mode (ext_edge bit = 0) requests while the pin is low and stops when the pin is high. Acknowledge does not clear it.
- R9: An external pin in edge mode (ext_edge bit = 1) latches a high-to-low transition. The latch stays set after the pin returns high and is cleared when its vector is acknowledged.
- R10: A capture pin latches a rising edge when its cap_rise bit is 1 and a falling edge when its cap_fall bit is 1. Both bits set means both edges are latched; an edge whose bit is 0 is ignored.
- R11: A latched capture request is cleared when its vector is acknowledged.
- R12: While idle is 1, capture edges are not latched. wake_req is 1 exactly when glob_en is 1 and an enabled non-capture source is pending.
- R13: The vector index is the source number: 0 INT-A pin, 1 INT-B pin, 2 timer A, 3 timer B, 4-7 capture 0-3, 8-10 compare 0-2, 11 capture-timer overflow, 12 ADC, 13 CAN, 14 UART. periph_req bits 0..8 map to sources 2, 3, 8, 9, 10, 11, 12, 13, 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins (sources 0, 1) |
| ext_edge | input | 2 | Per pin: 1 = edge mode, 0 = level mode |
| cap_pin | input | 4 | Capture pins (sources 4-7) |
| cap_rise | input | 4 | Per capture pin: latch rising edges |
| cap_fall | input | 4 | Per capture pin: latch falling edges |
| periph_req | input | 9 | Peripheral level requests |
| src_en | input | 15 | Per-source enable, indexed by vector |
| src_hi | input | 15 | Per-source priority (1 = high), indexed by vector |
| glob_en | input | 1 | Global enable |
| dma_busy | input | 1 | Blocks all grants while 1 |
| idle | input | 1 | Idle mode indicator |
| irq_ack | input | 1 | Processor accepts the current vector |
| irq_ret | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 4 | Vector index of the granted source |
| wake_req | output | 1 | Request that may end idle mode |

## Verification
Assertions check these rules on every cycle: DMA lockout, the blocking effect of a high-level routine, the rule that only high-priority sources are granted over a low-level routine, that every grant comes from an enabled pending source, what a return does to the two in-service bits, how the edge latches are held and cleared, and that capture latches stay frozen in idle. Other behaviour needs directed sequences that only the bench scenarios provide. These are the fixed order among equal-priority sources, the vector numbering, the exact difference between level-mode and edge-mode pins, the rising, falling and both-edge capture selection, and the full nest-and-unwind sequence with preemption.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 15;
    localparam int NEXT = 2;
    localparam int NCAP = 4;
    localparam int NPER = NSRC - NEXT - NCAP;
    localparam int VW   = $clog2(NSRC);

    typedef enum logic [VW-1:0] {
        SRC_EXA  = 4'd0,
        SRC_EXB  = 4'd1,
        SRC_TMA  = 4'd2,
        SRC_TMB  = 4'd3,
        SRC_CP0  = 4'd4,
        SRC_CP1  = 4'd5,
        SRC_CP2  = 4'd6,
        SRC_CP3  = 4'd7,
        SRC_CM0  = 4'd8,
        SRC_CM1  = 4'd9,
        SRC_CM2  = 4'd10,
        SRC_T2OV = 4'd11,
        SRC_ADC  = 4'd12,
        SRC_CAN  = 4'd13,
        SRC_UART = 4'd14
    } src_e;

    typedef logic [NSRC-1:0] srcvec_t;

    typedef struct packed {
        logic          valid;
        logic [VW-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic in_hi;
        logic in_lo;
    } insvc_t;

    localparam srcvec_t CAP_MASK = srcvec_t'(((1 << NCAP) - 1) << int'(SRC_CP0));

    // Lowest set index wins: fixed order among equal levels.
    function automatic pick_t pick_first(input srcvec_t v);
        pick_t p;
        p.valid = 1'b0;
        p.idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = VW'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond
    import irq_pkg::*;
#(
    parameter int N = NEXT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic smp_q, smp_d, latch_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                smp_q   <= 1'b1;
                smp_d   <= 1'b1;
                latch_q <= 1'b0;
            end else begin
                smp_q <= pin_n[i];
                smp_d <= smp_q;
                if (!edge_mode[i])
                    latch_q <= 1'b0;
                else if (smp_d && !smp_q)
                    latch_q <= 1'b1;
                else if (clr[i])
                    latch_q <= 1'b0;
            end
        end

        assign req[i] = edge_mode[i] ? latch_q : ~smp_q;

        // R9: a latched edge survives until an acknowledge clears it
        p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (edge_mode[i] && latch_q && !clr[i]) |=> latch_q);

        // R9: acknowledge without a new edge empties the latch
        p_edge_clear_r9: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !(smp_d && !smp_q)) |=> !latch_q);
    end

endmodule

// File: rtl/irq_cap_edge.sv
module irq_cap_edge
    import irq_pkg::*;
#(
    parameter int N = NCAP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic         idle,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_cap
        logic smp_q, smp_d, flag_q, hit;

        assign hit = !idle && ((smp_q && !smp_d && rise_en[i]) ||
                               (!smp_q && smp_d && fall_en[i]));

        always_ff @(posedge clk) begin
            if (rst) begin
                smp_q  <= 1'b0;
                smp_d  <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                smp_q <= pin[i];
                smp_d <= smp_q;
                if (hit)
                    flag_q <= 1'b1;
                else if (clr[i])
                    flag_q <= 1'b0;
            end
        end

        assign flag[i] = flag_q;

        // R12: capture latch frozen while the capture timer is stopped
        p_idle_freeze_r12: assert property (@(posedge clk) disable iff (rst)
            (idle && !clr[i]) |=> (flag_q == $past(flag_q)));

        // R11: acknowledge in idle always clears the latch
        p_cap_clear_r11: assert property (@(posedge clk) disable iff (rst)
            (idle && clr[i]) |=> !flag_q);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  srcvec_t       pend,
    input  srcvec_t       en,
    input  srcvec_t       hi,
    input  logic          glob_en,
    input  logic          dma_busy,
    input  logic          ack,
    input  logic          ret,
    output logic          req,
    output logic [VW-1:0] vec,
    output logic          take
);

    insvc_t  svc_q;
    srcvec_t live;
    pick_t   pk_hi, pk_lo;

    always_comb begin
        live  = pend & en & {NSRC{glob_en}};
        pk_hi = pick_first(live & hi);
        pk_lo = pick_first(live & ~hi);
        req   = 1'b0;
        vec   = '0;
        if (!dma_busy) begin
            if (!svc_q.in_hi && pk_hi.valid) begin
                req = 1'b1;
                vec = pk_hi.idx;
            end else if (!svc_q.in_hi && !svc_q.in_lo && pk_lo.valid) begin
                req = 1'b1;
                vec = pk_lo.idx;
            end
        end
    end

    assign take = ack && req;

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
        end else if (take) begin
            if (hi[vec]) svc_q.in_hi <= 1'b1;
            else         svc_q.in_lo <= 1'b1;
        end else if (ret) begin
            if (svc_q.in_hi) svc_q.in_hi <= 1'b0;
            else             svc_q.in_lo <= 1'b0;
        end
    end

    p_dma_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        dma_busy |-> !req);

    p_hi_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        svc_q.in_hi |-> !req);

    p_only_hi_over_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (svc_q.in_lo && req) |-> hi[vec]);

    p_grant_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        req |-> (glob_en && en[vec] && pend[vec]));

    p_ret_top_r6: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && svc_q.in_hi) |=> (!svc_q.in_hi && svc_q.in_lo == $past(svc_q.in_lo)));

    p_ack_marks_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> (svc_q.in_hi || svc_q.in_lo));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NEXT-1:0]      ext_pin_n,
    input  logic [NEXT-1:0]      ext_edge,
    input  logic [NCAP-1:0]      cap_pin,
    input  logic [NCAP-1:0]      cap_rise,
    input  logic [NCAP-1:0]      cap_fall,
    input  logic [NPER-1:0]      periph_req,
    input  logic [NSRC-1:0]      src_en,
    input  logic [NSRC-1:0]      src_hi,
    input  logic                 glob_en,
    input  logic                 dma_busy,
    input  logic                 idle,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_req,
    output logic [VW-1:0]        irq_vec,
    output logic                 wake_req
);

    logic [NEXT-1:0] ext_req, ext_clr;
    logic [NCAP-1:0] cap_flag, cap_clr;
    srcvec_t         pend;
    logic            take;

    for (genvar i = 0; i < NEXT; i++) begin : g_eclr
        assign ext_clr[i] = take && (irq_vec == VW'(int'(SRC_EXA) + i));
    end
    for (genvar i = 0; i < NCAP; i++) begin : g_cclr
        assign cap_clr[i] = take && (irq_vec == VW'(int'(SRC_CP0) + i));
    end

    irq_ext_cond #(.N(NEXT)) u_ext (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_pin_n),
        .edge_mode (ext_edge),
        .clr       (ext_clr),
        .req       (ext_req)
    );

    irq_cap_edge #(.N(NCAP)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .pin     (cap_pin),
        .rise_en (cap_rise),
        .fall_en (cap_fall),
        .idle    (idle),
        .clr     (cap_clr),
        .flag    (cap_flag)
    );

    always_comb begin
        pend                      = '0;
        pend[SRC_EXA]             = ext_req[0];
        pend[SRC_EXB]             = ext_req[1];
        pend[SRC_TMA]             = periph_req[0];
        pend[SRC_TMB]             = periph_req[1];
        pend[SRC_CP3:SRC_CP0]     = cap_flag;
        pend[SRC_UART:SRC_CM0]    = periph_req[NPER-1:2];
    end

    irq_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .en       (src_en),
        .hi       (src_hi),
        .glob_en  (glob_en),
        .dma_busy (dma_busy),
        .ack      (irq_ack),
        .ret      (irq_ret),
        .req      (irq_req),
        .vec      (irq_vec),
        .take     (take)
    );

    assign wake_req = glob_en && |(pend & src_en & ~CAP_MASK);

    // R12: a capture latch alone never raises the wake line
    p_cap_no_wake_r12: assert property (@(posedge clk) disable iff (rst)
        (periph_req == '0 && ext_req == '0) |-> !wake_req);

endmodule

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
    import irq_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic [NEXT-1:0] ext_pin_n, ext_edge;
    logic [NCAP-1:0] cap_pin, cap_rise, cap_fall;
    logic [NPER-1:0] periph_req;
    logic [NSRC-1:0] src_en, src_hi;
    logic glob_en, dma_busy, idle, irq_ack, irq_ret;
    logic irq_req, wake_req;
    logic [VW-1:0] irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_nest_ctrl u0 (
        .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
        .cap_pin(cap_pin), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .periph_req(periph_req), .src_en(src_en), .src_hi(src_hi),
        .glob_en(glob_en), .dma_busy(dma_busy), .idle(idle),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ext_pin_n = '1; ext_edge = '0;
        cap_pin = '0; cap_rise = '0; cap_fall = '0;
        periph_req = '0; src_en = '1; src_hi = '0;
        glob_en = 1'b1; dma_busy = 1'b0; idle = 1'b0;
        irq_ack = 1'b0; irq_ret = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
    endtask

    task automatic ret_pulse();
        irq_ret = 1'b1; step(1); irq_ret = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 vec", irq_vec, 0);
        chk("R1 wake", wake_req, 0);
        // R1: in-service clear, so a low request is granted at once
        periph_req[1] = 1'b1; step(1);
        chk("R1 req after reset", irq_req, 1);
    endtask

    task automatic t_order();
        do_reset();
        periph_req[0] = 1'b1; periph_req[6] = 1'b1; periph_req[8] = 1'b1;
        step(1);
        chk("R3 lowest index", irq_vec, 2);
        periph_req[0] = 1'b0; step(1);
        chk("R3 next in order", irq_vec, 12);
        periph_req = '0; periph_req[7] = 1'b1; step(1);
        chk("R13 CAN vector", irq_vec, 13);
        periph_req = '0; periph_req[2] = 1'b1; step(1);
        chk("R13 compare0 vector", irq_vec, 8);
    endtask

    task automatic t_enable();
        do_reset();
        periph_req[5] = 1'b1;
        glob_en = 1'b0; step(1);
        chk("R2 global off", irq_req, 0);
        glob_en = 1'b1; src_en[11] = 1'b0; step(1);
        chk("R2 source off", irq_req, 0);
        src_en[11] = 1'b1; step(1);
        chk("R2 enabled vec", irq_vec, 11);
    endtask

    task automatic t_dma();
        do_reset();
        periph_req[8] = 1'b1; dma_busy = 1'b1; step(2);
        chk("R7 dma blocks", irq_req, 0);
        dma_busy = 1'b0; step(1);
        chk("R7 after dma", irq_req, 1);
    endtask

    task automatic t_nest();
        do_reset();
        src_hi[12] = 1'b1; src_hi[14] = 1'b1;
        periph_req[1] = 1'b1; step(1);
        chk("R13 timerB vec", irq_vec, 3);
        ack_pulse();
        chk("R5 low over low", irq_req, 0);
        periph_req[6] = 1'b1; step(1);
        chk("R4 preempt req", irq_req, 1);
        chk("R4 preempt vec", irq_vec, 12);
        ack_pulse();
        periph_req[6] = 1'b0; periph_req[8] = 1'b1; step(1);
        chk("R5 hi over hi", irq_req, 0);
        ret_pulse();
        chk("R6 hi cleared vec", irq_vec, 14);
        chk("R6 hi cleared req", irq_req, 1);
        periph_req[8] = 1'b0; step(1);
        chk("R6 low kept", irq_req, 0);
        ret_pulse();
        chk("R6 low cleared", irq_req, 1);
        chk("R6 low vec", irq_vec, 3);
    endtask

    task automatic t_ext_level();
        do_reset();
        ext_pin_n[0] = 1'b0; step(2);
        chk("R8 level req", irq_req, 1);
        chk("R8 level vec", irq_vec, 0);
        ack_pulse(); ret_pulse();
        chk("R8 not cleared by ack", irq_req, 1);
        ext_pin_n[0] = 1'b1; step(2);
        chk("R8 pin high", irq_req, 0);
    endtask

    task automatic t_ext_edge();
        do_reset();
        ext_edge[1] = 1'b1; step(1);
        ext_pin_n[1] = 1'b0; step(1);
        ext_pin_n[1] = 1'b1; step(3);
        chk("R9 edge held", irq_req, 1);
        chk("R9 edge vec", irq_vec, 1);
        ack_pulse(); ret_pulse();
        chk("R9 cleared by ack", irq_req, 0);
    endtask

    task automatic t_cap();
        do_reset();
        cap_rise = 4'b0101; cap_fall = 4'b0110;
        cap_pin[0] = 1'b1; step(3);
        chk("R10 rise vec", irq_vec, 4);
        ack_pulse(); ret_pulse();
        chk("R11 cleared", irq_req, 0);
        cap_pin[0] = 1'b0; step(3);
        chk("R10 fall ignored", irq_req, 0);
        cap_pin[1] = 1'b1; step(3);
        chk("R10 rise ignored", irq_req, 0);
        cap_pin[1] = 1'b0; step(3);
        chk("R10 fall vec", irq_vec, 5);
        ack_pulse(); ret_pulse();
        cap_pin[2] = 1'b1; step(3);
        chk("R10 both rise", irq_vec, 6);
        ack_pulse(); ret_pulse();
        chk("R11 both cleared", irq_req, 0);
        cap_pin[2] = 1'b0; step(3);
        chk("R10 both fall", irq_req, 1);
    endtask

    task automatic t_idle();
        do_reset();
        cap_rise[3] = 1'b1; cap_fall[3] = 1'b1; idle = 1'b1;
        cap_pin[3] = 1'b1; step(3);
        cap_pin[3] = 1'b0; step(3);
        chk("R12 no wake from capture", wake_req, 0);
        chk("R12 no capture latch", irq_req, 0);
        periph_req[7] = 1'b1; step(1);
        chk("R12 wake from CAN", wake_req, 1);
        idle = 1'b0; periph_req[7] = 1'b0; step(2);
        chk("R12 nothing latched", irq_req, 0);
        chk("R12 wake low", wake_req, 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_enable();
        t_dma();
        t_nest();
        t_ext_level();
        t_ext_edge();
        t_cap();
        t_idle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule